// File: doc/BRIEF.md
# Flash Write Completion Status Logic

This block holds both halves of the completion handshake that a non-volatile array uses while an internal program or erase runs. The device half sits beside the array. Each read strobe gets a registered response. While the array is busy, the response encodes the operation state in two status bits. Bit 7 carries an inverted or zeroed copy of the target bit. Bit 6 flips on every read. After the operation ends, the device half holds back the remaining data bits for a short settling period.

The host half is a poller that starts after software has issued a write command. It reads the target location one request at a time and decides that the write has finished by one of two methods. The first compares bit 7 with the expected value. The second watches for bit 6 to stop changing. Before it reports success, the poller reads the location twice more to confirm. A bounded read budget turns a write that never completes into an error. The two halves have separate ports, so the host side can be wired to this block's own device side or to another one.

Top module: `wsr_top`

## Requirements
- R1: While the array is busy with a program (`arr_busy`=1, `arr_erase`=0), a read returns the stored word with bit 7 inverted and bit 6 replaced by the toggle value. All other bits are unchanged.
- R2: While the array is busy with an erase (`arr_erase`=1), a read returns zero in every bit except bit 6, which carries the toggle value. Bit 7 therefore reads 0.
- R3: The toggle value is cleared to 0 when `arr_busy` rises. It inverts after each read made while busy, so successive busy reads return bit 6 as 0, 1, 0, and so on.
- R4: Once `arr_busy` falls, bit 6 stops changing. The first `SETTLE_RD` reads return the true bit 7, the frozen toggle value in bit 6 and zero in all other bits. Every later read returns the stored word unchanged.
- R5: `dev_rvld` is high exactly in the cycle after `dev_rd`. `dev_rdata` keeps its value until the next read.
- R6: The poller keeps at most one read outstanding, and `hst_rd` is never high for two cycles in a row. In bit-7 mode (`hst_toggle`=0), a read passes when bit 7 equals the target. The target is `hst_prog_bit` for a program and 1 for an erase.
- R7: In toggle mode (`hst_toggle`=1), a read passes when its bit 6 equals bit 6 of the previous read of the same run. The first read of a run never passes.
- R8: One passing read is only a candidate for completion. Completion needs two further passing reads directly after it. Any failing read cancels the candidate, polling goes on, and `hst_done` stays low.
- R9: On completion, `hst_done` goes high, `hst_result` takes the data of the final read and `hst_active` goes low. These hold until the next accepted `hst_start`. With `SETTLE_RD` of 2 or less, `hst_result` equals the stored word.
- R10: If `MAX_POLLS` reads finish without completion, `hst_err` goes high and `hst_active` goes low. `hst_done` is never high together with `hst_err`.
- R11: During reset `dev_rvld`, `hst_rd`, `hst_done`, `hst_err` and `hst_active` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| arr_busy | input | 1 | Array internal operation running |
| arr_erase | input | 1 | Running operation is an erase (else program) |
| arr_data | input | DATA_W | Word stored at, or being written to, the read location |
| dev_rd | input | 1 | Device-side read strobe |
| dev_rdata | output | DATA_W | Device-side read response |
| dev_rvld | output | 1 | Response valid |
| hst_start | input | 1 | Begin polling (accepted when idle) |
| hst_toggle | input | 1 | 1: toggle-bit method, 0: bit-7 method |
| hst_erase | input | 1 | Polled operation is an erase |
| hst_prog_bit | input | 1 | Expected bit 7 of programmed word |
| hst_rd | output | 1 | Host read request |
| hst_rdata | input | DATA_W | Host read response data |
| hst_rvld | input | 1 | Host read response valid |
| hst_done | output | 1 | Completion confirmed |
| hst_err | output | 1 | Read budget exhausted |
| hst_result | output | DATA_W | Data of the confirming read |
| hst_active | output | 1 | Poller running |

## Verification
The device side is driven directly with program and erase runs. The program runs use stored words whose bit 7 is set in some cases and clear in others, so an inverted status bit can be told apart from a passed-through one. Reads across the fall of busy separate the settling reads from the full-data reads. The poller is run in both methods for program and erase, for busy times that are zero, one cycle, moderate and far beyond the budget. These runs separate clean completion, an operation that is already finished, and a timeout. A directed case drops busy for exactly one read and then raises it again. It shows that a single lucky read is rejected by the confirm reads and that completion is still found later.

// File: rtl/wsr_pkg.sv
package wsr_pkg;
    localparam int STAT_BIT = 7;
    localparam int TOG_BIT  = 6;

    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_REQ  = 2'd1,
        PS_WAIT = 2'd2
    } poll_st_e;
endpackage

// File: rtl/wsr_reporter.sv
module wsr_reporter
    import wsr_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int SETTLE_RD = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arr_busy,
    input  logic              arr_erase,
    input  logic [DATA_W-1:0] arr_data,
    input  logic              rd,
    output logic [DATA_W-1:0] rdata,
    output logic              rvld
);
    localparam int SW = (SETTLE_RD > 0) ? $clog2(SETTLE_RD + 1) : 1;

    typedef struct packed {
        logic              tog;
        logic              busy;
        logic [SW-1:0]     settle;
        logic [DATA_W-1:0] dout;
        logic              vld;
    } rep_s;

    rep_s q, d;
    logic              tog_now;
    logic [SW-1:0]     settle_now;
    logic [DATA_W-1:0] resp;

    always_comb begin
        d       = q;
        d.busy  = arr_busy;
        d.vld   = rd;
        tog_now = (arr_busy && !q.busy) ? 1'b0 : q.tog;
        settle_now = q.busy ? SW'(SETTLE_RD) : q.settle;
        resp    = arr_data;

        if (arr_busy) begin
            d.settle = '0;
            d.tog    = rd ? ~tog_now : tog_now;
            if (arr_erase) begin
                resp = '0;
            end else begin
                resp           = arr_data;
                resp[STAT_BIT] = ~arr_data[STAT_BIT];
            end
            resp[TOG_BIT] = tog_now;
        end else begin
            d.tog    = q.tog;
            d.settle = settle_now;
            if (settle_now != '0) begin
                resp           = '0;
                resp[STAT_BIT] = arr_data[STAT_BIT];
                resp[TOG_BIT]  = q.tog;
                if (rd) begin
                    d.settle = settle_now - SW'(1);
                end
            end
        end

        if (rd) begin
            d.dout = resp;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rdata = q.dout;
    assign rvld  = q.vld;
endmodule

// File: rtl/wsr_poller.sv
module wsr_poller
    import wsr_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int MAX_POLLS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              use_toggle,
    input  logic              is_erase,
    input  logic              prog_bit,
    output logic              rd,
    input  logic [DATA_W-1:0] rdata,
    input  logic              rvld,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] result,
    output logic              active
);
    localparam int CW = $clog2(MAX_POLLS + 1);

    typedef struct packed {
        poll_st_e          st;
        logic              tmode;
        logic              tgt;
        logic [CW-1:0]     reads;
        logic [1:0]        conf;
        logic              prev6;
        logic              have_prev;
        logic              done;
        logic              err;
        logic [DATA_W-1:0] result;
    } poll_s;

    poll_s q, d;
    logic          pass;
    logic [CW-1:0] reads_nx;

    always_comb begin
        d        = q;
        reads_nx = q.reads + CW'(1);
        pass     = q.tmode ? (q.have_prev && (rdata[TOG_BIT] == q.prev6))
                           : (rdata[STAT_BIT] == q.tgt);

        case (q.st)
            PS_IDLE: begin
                if (start) begin
                    d.tmode     = use_toggle;
                    d.tgt       = is_erase ? 1'b1 : prog_bit;
                    d.reads     = '0;
                    d.conf      = 2'd0;
                    d.have_prev = 1'b0;
                    d.done      = 1'b0;
                    d.err       = 1'b0;
                    d.st        = PS_REQ;
                end
            end
            PS_REQ: begin
                d.st = PS_WAIT;
            end
            PS_WAIT: begin
                if (rvld) begin
                    d.reads     = reads_nx;
                    d.prev6     = rdata[TOG_BIT];
                    d.have_prev = 1'b1;
                    if (pass && (q.conf == 2'd2)) begin
                        d.done   = 1'b1;
                        d.result = rdata;
                        d.st     = PS_IDLE;
                    end else begin
                        d.conf = pass ? (q.conf + 2'd1) : 2'd0;
                        if (reads_nx == CW'(MAX_POLLS)) begin
                            d.err = 1'b1;
                            d.st  = PS_IDLE;
                        end else begin
                            d.st = PS_REQ;
                        end
                    end
                end
            end
            default: begin
                d.st = PS_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rd     = (q.st == PS_REQ);
    assign done   = q.done;
    assign err    = q.err;
    assign result = q.result;
    assign active = (q.st != PS_IDLE);
endmodule

// File: rtl/wsr_top.sv
module wsr_top #(
    parameter int DATA_W    = 16,
    parameter int SETTLE_RD = 1,
    parameter int MAX_POLLS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arr_busy,
    input  logic              arr_erase,
    input  logic [DATA_W-1:0] arr_data,
    input  logic              dev_rd,
    output logic [DATA_W-1:0] dev_rdata,
    output logic              dev_rvld,
    input  logic              hst_start,
    input  logic              hst_toggle,
    input  logic              hst_erase,
    input  logic              hst_prog_bit,
    output logic              hst_rd,
    input  logic [DATA_W-1:0] hst_rdata,
    input  logic              hst_rvld,
    output logic              hst_done,
    output logic              hst_err,
    output logic [DATA_W-1:0] hst_result,
    output logic              hst_active
);
    wsr_reporter #(
        .DATA_W    (DATA_W),
        .SETTLE_RD (SETTLE_RD)
    ) u_rep (
        .clk       (clk),
        .rst_n     (rst_n),
        .arr_busy  (arr_busy),
        .arr_erase (arr_erase),
        .arr_data  (arr_data),
        .rd        (dev_rd),
        .rdata     (dev_rdata),
        .rvld      (dev_rvld)
    );

    wsr_poller #(
        .DATA_W    (DATA_W),
        .MAX_POLLS (MAX_POLLS)
    ) u_pol (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (hst_start),
        .use_toggle (hst_toggle),
        .is_erase   (hst_erase),
        .prog_bit   (hst_prog_bit),
        .rd         (hst_rd),
        .rdata      (hst_rdata),
        .rvld       (hst_rvld),
        .done       (hst_done),
        .err        (hst_err),
        .result     (hst_result),
        .active     (hst_active)
    );
endmodule

// File: rtl/wsr_top_chk.sv
module wsr_top_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              arr_busy,
    input logic              arr_erase,
    input logic              arr_bit7,
    input logic              dev_rd,
    input logic [DATA_W-1:0] dev_rdata,
    input logic              dev_rvld,
    input logic              hst_rd,
    input logic              hst_done,
    input logic              hst_err,
    input logic              hst_active
);
    // R1: program status bit is the inverse of the stored bit
    a_r1_prog_inverts: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_rd && arr_busy && !arr_erase) |=> (dev_rdata[7] != $past(arr_bit7)));

    // R2: erase status bit reads zero
    a_r2_erase_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_rd && arr_busy && arr_erase) |=> !dev_rdata[7]);

    // R3: back-to-back busy reads alternate bit 6
    a_r3_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_rd && arr_busy && $past(dev_rd && arr_busy)) |=> (dev_rdata[6] != $past(dev_rdata[6])));

    // R5: response valid follows a strobe
    a_r5_rvld_follows: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rd |=> dev_rvld);

    // R5: no strobe, no valid, data held
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_rd |=> (!dev_rvld && $stable(dev_rdata)));

    // R6: single-cycle requests
    a_r6_one_req: assert property (@(posedge clk) disable iff (!rst_n)
        hst_rd |=> !hst_rd);

    // R9: done implies idle
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        hst_done |-> !hst_active);

    // R10: done and error exclusive
    a_r10_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(hst_done && hst_err));
endmodule

bind wsr_top wsr_top_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .arr_busy   (arr_busy),
    .arr_erase  (arr_erase),
    .arr_bit7   (arr_data[7]),
    .dev_rd     (dev_rd),
    .dev_rdata  (dev_rdata),
    .dev_rvld   (dev_rvld),
    .hst_rd     (hst_rd),
    .hst_done   (hst_done),
    .hst_err    (hst_err),
    .hst_active (hst_active)
);

// File: tb/sim_wsr_top.sv
module sim_wsr_top;
    localparam int DW   = 16;
    localparam int MAXP = 64;

    typedef struct packed {
        logic        tmode;
        logic        erase;
        logic [15:0] data;
        logic [15:0] blen;
        logic        exp_err;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{1'b0, 1'b0, 16'h1234, 16'd30,  1'b0},
        '{1'b0, 1'b0, 16'h00C3, 16'd30,  1'b0},
        '{1'b0, 1'b1, 16'hFFFF, 16'd40,  1'b0},
        '{1'b1, 1'b0, 16'h5A5A, 16'd30,  1'b0},
        '{1'b1, 1'b1, 16'hFFFF, 16'd50,  1'b0},
        '{1'b0, 1'b0, 16'h0080, 16'd0,   1'b0},
        '{1'b1, 1'b0, 16'h7F01, 16'd1,   1'b0},
        '{1'b0, 1'b0, 16'h2222, 16'd400, 1'b1},
        '{1'b1, 1'b1, 16'hFFFF, 16'd400, 1'b1}
    };

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n, arr_busy, arr_erase;
    logic [DW-1:0] arr_data, dev_rdata, hst_result;
    logic          dev_rd, dev_rvld, hst_start, hst_toggle, hst_erase, hst_prog_bit;
    logic          hst_rd, hst_rvld, hst_done, hst_err, hst_active;
    logic          dir_mode, dir_rd;

    assign dev_rd   = dir_mode ? dir_rd : hst_rd;
    assign hst_rvld = dir_mode ? 1'b0 : dev_rvld;

    wsr_top #(.DATA_W(DW), .SETTLE_RD(1), .MAX_POLLS(MAXP)) u0 (
        .clk(clk), .rst_n(rst_n), .arr_busy(arr_busy), .arr_erase(arr_erase),
        .arr_data(arr_data), .dev_rd(dev_rd), .dev_rdata(dev_rdata), .dev_rvld(dev_rvld),
        .hst_start(hst_start), .hst_toggle(hst_toggle), .hst_erase(hst_erase),
        .hst_prog_bit(hst_prog_bit), .hst_rd(hst_rd), .hst_rdata(dev_rdata),
        .hst_rvld(hst_rvld), .hst_done(hst_done), .hst_err(hst_err),
        .hst_result(hst_result), .hst_active(hst_active)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    task automatic dread(output logic [DW-1:0] v);
        @(negedge clk) dir_rd = 1'b1;
        @(negedge clk) dir_rd = 1'b0;
        v = dev_rdata;
    endtask

    function automatic logic [DW-1:0] prog_busy(input logic [DW-1:0] w, input logic t);
        logic [DW-1:0] r;
        r    = w ^ 16'h0080;
        r[6] = t;
        return r;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        int nreq;
        int cyc;
        rst_n = 1'b0; arr_busy = 1'b0; arr_erase = 1'b0; arr_data = '0;
        hst_start = 1'b0; hst_toggle = 1'b0; hst_erase = 1'b0; hst_prog_bit = 1'b0;
        dir_mode = 1'b1; dir_rd = 1'b0;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(dev_rvld == 1'b0, "R11 dev_rvld", 32'(dev_rvld), 0);
        chk(hst_rd == 1'b0, "R11 hst_rd", 32'(hst_rd), 0);
        chk(hst_done == 1'b0, "R11 hst_done", 32'(hst_done), 0);
        chk(hst_err == 1'b0, "R11 hst_err", 32'(hst_err), 0);
        chk(hst_active == 1'b0, "R11 hst_active", 32'(hst_active), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R3 program busy reads
        arr_data = 16'h00A5; arr_erase = 1'b0; arr_busy = 1'b1;
        @(negedge clk);
        dread(v); chk(v == prog_busy(16'h00A5, 1'b0), "R1 R3 read1", 32'(v), 32'(prog_busy(16'h00A5, 1'b0)));
        chk(dev_rvld == 1'b1, "R5 rvld after strobe", 32'(dev_rvld), 1);
        @(negedge clk);
        chk(dev_rvld == 1'b0 && dev_rdata == v, "R5 hold", 32'(dev_rdata), 32'(v));
        dread(v); chk(v == prog_busy(16'h00A5, 1'b1), "R1 R3 read2", 32'(v), 32'(prog_busy(16'h00A5, 1'b1)));
        dread(v); chk(v == prog_busy(16'h00A5, 1'b0), "R3 read3", 32'(v), 32'(prog_busy(16'h00A5, 1'b0)));
        // R4 completion: toggle frozen at 1, one settling read
        @(negedge clk) arr_busy = 1'b0;
        dread(v); chk(v == 16'h00C0, "R4 settle read", 32'(v), 32'h00C0);
        dread(v); chk(v == 16'h00A5, "R4 full data", 32'(v), 32'h00A5);
        dread(v); chk(v == 16'h00A5, "R4 stays full", 32'(v), 32'h00A5);

        // R2 / R3 erase busy reads, toggle restarts at 0
        arr_data = 16'hFFFF; arr_erase = 1'b1; arr_busy = 1'b1;
        @(negedge clk);
        dread(v); chk(v == 16'h0000, "R2 R3 erase read1", 32'(v), 0);
        dread(v); chk(v == 16'h0040, "R2 R3 erase read2", 32'(v), 32'h0040);
        @(negedge clk) arr_busy = 1'b0;
        dread(v); chk(v == 16'h0080, "R4 erase settle", 32'(v), 32'h0080);
        dread(v); chk(v == 16'hFFFF, "R4 erase full", 32'(v), 32'hFFFF);

        // Poller vectors (R6 R7 R9 R10)
        dir_mode = 1'b0;
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            arr_data = VECS[i].data; arr_erase = VECS[i].erase;
            arr_busy = (VECS[i].blen != 16'd0);
            hst_start = 1'b1; hst_toggle = VECS[i].tmode; hst_erase = VECS[i].erase;
            hst_prog_bit = VECS[i].data[7];
            @(negedge clk);
            hst_start = 1'b0;
            nreq = 0;
            cyc = 1;
            while (!(hst_done || hst_err) && cyc < 2000) begin
                if (cyc >= int'(VECS[i].blen)) arr_busy = 1'b0;
                if (hst_rd) nreq++;
                @(negedge clk);
                cyc++;
            end
            if (VECS[i].exp_err) begin
                chk(hst_err == 1'b1 && hst_done == 1'b0, "R10 timeout err", 32'({hst_done, hst_err}), 32'h1);
                chk(nreq == MAXP, "R10 read budget", 32'(nreq), 32'(MAXP));
            end else begin
                chk(hst_done == 1'b1 && hst_err == 1'b0,
                    VECS[i].tmode ? "R7 toggle done" : "R6 bit7 done", 32'({hst_done, hst_err}), 32'h2);
                chk(hst_result == VECS[i].data, "R9 result", 32'(hst_result), 32'(VECS[i].data));
            end
            chk(hst_active == 1'b0, "R9 R10 idle", 32'(hst_active), 0);
            arr_busy = 1'b0;
            repeat (2) @(negedge clk);
            chk(hst_done == !VECS[i].exp_err && hst_err == VECS[i].exp_err, "R9 R10 held",
                32'({hst_done, hst_err}), 32'({!VECS[i].exp_err, VECS[i].exp_err}));
        end

        // R8: one lucky read during busy must be rejected by the confirm reads
        @(negedge clk);
        arr_data = 16'h0011; arr_erase = 1'b0; arr_busy = 1'b1;
        hst_start = 1'b1; hst_toggle = 1'b0; hst_erase = 1'b0; hst_prog_bit = 1'b0;
        @(negedge clk) hst_start = 1'b0;
        cyc = 0;
        while (!hst_rvld && cyc < 50) begin @(negedge clk); cyc++; end
        arr_busy = 1'b0;
        @(negedge clk);
        cyc = 0;
        while (!hst_rvld && cyc < 50) begin @(negedge clk); cyc++; end
        arr_busy = 1'b1;
        repeat (20) @(negedge clk);
        chk(hst_done == 1'b0 && hst_active == 1'b1, "R8 candidate rejected",
            32'({hst_done, hst_active}), 32'h1);
        arr_busy = 1'b0;
        cyc = 0;
        while (!(hst_done || hst_err) && cyc < 500) begin @(negedge clk); cyc++; end
        chk(hst_done == 1'b1 && hst_err == 1'b0, "R8 later done", 32'({hst_done, hst_err}), 32'h2);
        chk(hst_result == 16'h0011, "R8 R9 result", 32'(hst_result), 32'h0011);

        summary();
        $finish;
    end
endmodule